// File: doc/BRIEF.md
# Wide Special Register File with Key Windows

This block is the index-addressed file of 256-bit special registers that sits beside the datapath of a big-number arithmetic core. A 3-bit index selects one of eight slots. Two slots, the modulus and the accumulator, are ordinary storage. Two slots pass values through from external random sources that arrive on ports. The remaining four slots are read-only windows onto two 384-bit keys that are loaded from outside the core.

Instruction writes to the modulus and accumulator are staged and only land when the instruction commits. An abort discards them. A wipe command stages a poisoned (invalid) value that commits as a no-op. A start-of-operation pulse clears both stored registers.

Key data and key valid bits are not staged. A new key, or a withdrawn one, shows on the read port in the same cycle. Commit and abort have no effect on key data. For each of the two staged registers, a three-state machine tracks what is pending:
- **CLEAN**: nothing is pending.
- **HELD**: a value is waiting for commit.
- **POISON**: an invalid value is waiting for commit.

The named transitions are:
- *stage*: CLEAN/HELD/POISON to HELD, on a write.
- *poison*: any state to POISON, on a wipe.
- *retire*: to CLEAN on commit. The value is loaded only from HELD.
- *drop*: to CLEAN on abort.
- *restart*: to CLEAN on start, with the value cleared.

Top module: `wsr_bank`

## Requirements
- R1: Slot indices are fixed: 0 modulus, 1 first random source, 2 second random source, 3 accumulator, 4 key0 low, 5 key0 high, 6 key1 low, 7 key1 high. Reads are combinational from `rd_idx_i`. Slots 1 and 2 return `rnd_data_i` and `urnd_data_i`.
- R2: A low key window returns key bits 255:0 when that key is valid.
- R3: A high key window returns key bits 383:256 in bits 127:0, with bits 255:128 zero, when that key is valid.
- R4: `rd_has_value_o` equals the key's valid bit for slots 4 to 7 and is 1 for slots 0 to 3. A key window of an invalid key reads as zero.
- R5: Writes to slots 1, 2, 4, 5, 6 and 7 change nothing that can be read, even after a commit.
- R6: A write to slot 0 or 3 is not visible until a commit strobe. After the clock edge that samples the commit, the slot reads the written value.
- R7: An abort strobe discards the pending write, and the stored value is kept.
- R8: A start pulse sets slots 0 and 3 to zero after its edge and drops any pending write.
- R9: A key's data and valid inputs reach the read port in the same cycle. Neither commit nor abort nor start alters what the key windows return.
- R10: A wipe stages an invalid value in slots 0 and 3. A commit of it leaves the stored value unchanged. A later write replaces the poisoned entry, and a later wipe replaces a pending write.
- R11: Precedence within one cycle is start, then abort, then commit, then wipe, then write. A write or wipe presented together with commit, abort or start is dropped, and a write together with a wipe is dropped.
- R12: `rd_word_o` equals bits 31:0 of the selected slot, and `idx_ok_o` is 1 for every index.
- R13: After reset, slots 0 and 3 read zero and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-operation pulse |
| commit_i | input | 1 | Commit strobe for staged writes |
| abort_i | input | 1 | Abort strobe, discards staged writes |
| wipe_i | input | 1 | Stage an invalid value in slots 0 and 3 |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 3 | Write slot index |
| wr_data_i | input | 256 | Write data |
| rd_idx_i | input | 3 | Read slot index |
| rd_data_o | output | 256 | Selected slot contents |
| rd_word_o | output | 32 | Low 32 bits of the selected slot |
| rd_has_value_o | output | 1 | Selected slot holds a value |
| idx_ok_o | output | 1 | Index is in range (always 1) |
| rnd_data_i | input | 256 | First random source |
| urnd_data_i | input | 256 | Second random source |
| key0_valid_i | input | 1 | Key 0 valid |
| key0_data_i | input | 384 | Key 0 data |
| key1_valid_i | input | 1 | Key 1 valid |
| key1_data_i | input | 384 | Key 1 data |

## Verification
Faults in the staging machine show up at the read port on the first read of slot 0 or 3 after the offending strobe edge:
- A machine stuck in HELD after an abort shows as a value appearing at the next commit.
- A lost POISON state shows as stale pending data landing.
- A start that fails to clear shows as a nonzero read one cycle later.

Key faults are visible combinationally in the same cycle the key inputs change, so every sweep over all eight indices exposes a wrong slice, a wrong zero-extension or a wrong valid mapping at once.

// File: rtl/wsr_bank_pkg.sv
package wsr_bank_pkg;

    localparam int unsigned IDX_W = 3;
    localparam int unsigned SLOTS = 1 << IDX_W;

    typedef enum logic [IDX_W-1:0] {
        SLOT_MOD   = 3'd0,
        SLOT_RND   = 3'd1,
        SLOT_URND  = 3'd2,
        SLOT_ACC   = 3'd3,
        SLOT_K0_LO = 3'd4,
        SLOT_K0_HI = 3'd5,
        SLOT_K1_LO = 3'd6,
        SLOT_K1_HI = 3'd7
    } slot_e;

    // Pending state of one staged register
    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_HELD   = 2'd1,
        ST_POISON = 2'd2
    } stage_e;

endpackage

// File: rtl/wsr_stage_reg.sv
module wsr_stage_reg
    import wsr_bank_pkg::*;
#(
    parameter int unsigned W = 256
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         commit_i,
    input  logic         abort_i,
    input  logic         wipe_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] value_o
);

    stage_e         state_q, state_d;
    logic [W-1:0]   value_q;
    logic [W-1:0]   pend_q;
    logic           clear_val;
    logic           load_val;
    logic           load_pend;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: restart > drop > retire > poison > stage
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN, ST_HELD, ST_POISON: begin
                if (start_i || abort_i || commit_i) begin
                    state_d = ST_CLEAN;
                end else if (wipe_i) begin
                    state_d = ST_POISON;
                end else if (wr_i) begin
                    state_d = ST_HELD;
                end
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // Outputs of the machine: data register controls
    always_comb begin
        clear_val = start_i;
        load_val  = 1'b0;
        load_pend = 1'b0;
        unique case (state_q)
            ST_HELD: begin
                load_val  = !start_i && !abort_i && commit_i;
                load_pend = !start_i && !abort_i && !commit_i && !wipe_i && wr_i;
            end
            ST_CLEAN, ST_POISON: begin
                load_pend = !start_i && !abort_i && !commit_i && !wipe_i && wr_i;
            end
            default: begin
                load_pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            value_q <= '0;
            pend_q  <= '0;
        end else begin
            if (clear_val) begin
                value_q <= '0;
            end else if (load_val) begin
                value_q <= pend_q;
            end
            if (load_pend) begin
                pend_q <= wr_data_i;
            end
        end
    end

    assign value_o = value_q;

endmodule

// File: rtl/wsr_key_window.sv
module wsr_key_window #(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned KEY_W  = 384
) (
    input  logic [KEY_W-1:0]  key_i,
    input  logic              valid_i,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o
);

    localparam int unsigned PAD_W = 2 * DATA_W - KEY_W;

    logic [2*DATA_W-1:0] padded;

    assign padded = {{PAD_W{1'b0}}, key_i};
    assign lo_o   = valid_i ? padded[DATA_W-1:0]        : '0;
    assign hi_o   = valid_i ? padded[2*DATA_W-1:DATA_W] : '0;

endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux
    import wsr_bank_pkg::*;
#(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned WORD_W = 32
) (
    input  logic [DATA_W-1:0] slot_val_i [SLOTS],
    input  logic [SLOTS-1:0]  slot_has_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] data_o,
    output logic [WORD_W-1:0] word_o,
    output logic              has_o
);

    always_comb begin
        data_o = slot_val_i[idx_i];
        has_o  = slot_has_i[idx_i];
    end

    assign word_o = data_o[WORD_W-1:0];

endmodule

// File: rtl/wsr_bank.sv
module wsr_bank
    import wsr_bank_pkg::*;
#(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned KEY_W  = 384,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              commit_i,
    input  logic              abort_i,
    input  logic              wipe_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [2:0]        rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              rd_has_value_o,
    output logic              idx_ok_o,
    input  logic [DATA_W-1:0] rnd_data_i,
    input  logic [DATA_W-1:0] urnd_data_i,
    input  logic              key0_valid_i,
    input  logic [KEY_W-1:0]  key0_data_i,
    input  logic              key1_valid_i,
    input  logic [KEY_W-1:0]  key1_data_i
);

    localparam int unsigned N_PLAIN = 2;
    localparam int unsigned N_KEYS  = 2;

    logic [DATA_W-1:0] plain_val [N_PLAIN];
    logic [KEY_W-1:0]  key_data  [N_KEYS];
    logic [N_KEYS-1:0] key_vld;
    logic [DATA_W-1:0] key_lo    [N_KEYS];
    logic [DATA_W-1:0] key_hi    [N_KEYS];
    logic [DATA_W-1:0] slot_val  [SLOTS];
    logic [SLOTS-1:0]  slot_has;

    assign key_data[0] = key0_data_i;
    assign key_data[1] = key1_data_i;
    assign key_vld     = {key1_valid_i, key0_valid_i};

    // Staged registers: modulus and accumulator
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
        localparam logic [IDX_W-1:0] MY_IDX = (g == 0) ? SLOT_MOD : SLOT_ACC;
        logic wr_hit;
        assign wr_hit = wr_en_i && (wr_idx_i == MY_IDX);
        wsr_stage_reg #(.W(DATA_W)) u_stage (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .start_i   (start_i),
            .commit_i  (commit_i),
            .abort_i   (abort_i),
            .wipe_i    (wipe_i),
            .wr_i      (wr_hit),
            .wr_data_i (wr_data_i),
            .value_o   (plain_val[g])
        );
    end

    // Key windows, combinational from the sideload inputs
    for (genvar k = 0; k < N_KEYS; k++) begin : g_key
        wsr_key_window #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_win (
            .key_i   (key_data[k]),
            .valid_i (key_vld[k]),
            .lo_o    (key_lo[k]),
            .hi_o    (key_hi[k])
        );
    end

    always_comb begin
        slot_val[SLOT_MOD]   = plain_val[0];
        slot_val[SLOT_RND]   = rnd_data_i;
        slot_val[SLOT_URND]  = urnd_data_i;
        slot_val[SLOT_ACC]   = plain_val[1];
        slot_val[SLOT_K0_LO] = key_lo[0];
        slot_val[SLOT_K0_HI] = key_hi[0];
        slot_val[SLOT_K1_LO] = key_lo[1];
        slot_val[SLOT_K1_HI] = key_hi[1];
        slot_has             = {key_vld[1], key_vld[1], key_vld[0], key_vld[0], 4'b1111};
    end

    wsr_read_mux #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_mux (
        .slot_val_i (slot_val),
        .slot_has_i (slot_has),
        .idx_i      (rd_idx_i),
        .data_o     (rd_data_o),
        .word_o     (rd_word_o),
        .has_o      (rd_has_value_o)
    );

    // A 3-bit index always names a slot
    assign idx_ok_o = 1'b1;

endmodule

// File: rtl/wsr_bank_chk.sv
module wsr_bank_chk #(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned KEY_W  = 384
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              commit_i,
    input logic              abort_i,
    input logic [2:0]        rd_idx_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rd_has_value_o,
    input logic              key0_valid_i,
    input logic [KEY_W-1:0]  key0_data_i
);

    logic armed;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R6: without commit or start the modulus read does not move
    assert_mod_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (rd_idx_i == 3'd0 && $past(rd_idx_i) == 3'd0 && !$past(commit_i) && !$past(start_i))
        |-> $stable(rd_data_o));

    // R7: an abort edge leaves the accumulator as it was
    assert_abort_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        (rd_idx_i == 3'd3 && $past(rd_idx_i) == 3'd3 && $past(abort_i) && !$past(start_i))
        |-> $stable(rd_data_o));

    // R8: after a start edge both stored slots read zero
    assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
        ($past(start_i) && (rd_idx_i == 3'd0 || rd_idx_i == 3'd3)) |-> (rd_data_o == '0));

    // R4: non-key slots always hold a value
    assert_has_plain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_idx_i[2] == 1'b0) |-> rd_has_value_o);

    // R4: key0 windows follow key0 valid
    assert_has_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_idx_i == 3'd4 || rd_idx_i == 3'd5) |-> (rd_has_value_o == key0_valid_i));

    // R2: key0 low window carries the low key bits
    assert_key_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_idx_i == 3'd4 && key0_valid_i) |-> (rd_data_o == key0_data_i[DATA_W-1:0]));

endmodule

bind wsr_bank wsr_bank_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/wsr_bank_test.sv
module wsr_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 256;
    localparam int KW = 384;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          start_i = 1'b0, commit_i = 1'b0, abort_i = 1'b0, wipe_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [2:0]    wr_idx_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic [2:0]    rd_idx_i = '0;
    logic [DW-1:0] rd_data_o;
    logic [31:0]   rd_word_o;
    logic          rd_has_value_o, idx_ok_o;
    logic [DW-1:0] rnd_data_i = '0, urnd_data_i = '0;
    logic          key0_valid_i = 1'b0, key1_valid_i = 1'b0;
    logic [KW-1:0] key0_data_i = '0, key1_data_i = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Bench-side model of the stored registers
    logic [DW-1:0] mod_m = '0, acc_m = '0;

    wsr_bank uut (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .commit_i(commit_i),
        .abort_i(abort_i), .wipe_i(wipe_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .rd_word_o(rd_word_o), .rd_has_value_o(rd_has_value_o), .idx_ok_o(idx_ok_o),
        .rnd_data_i(rnd_data_i), .urnd_data_i(urnd_data_i),
        .key0_valid_i(key0_valid_i), .key0_data_i(key0_data_i),
        .key1_valid_i(key1_valid_i), .key1_data_i(key1_data_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat256(int s);
        logic [DW-1:0] r;
        for (int w = 0; w < 8; w++) r[w*32 +: 32] = (s * 32'h9E3779B1) ^ (w * 32'h01030507) ^ 32'h5A5A0000;
        return r;
    endfunction

    function automatic logic [KW-1:0] pat384(int s);
        logic [KW-1:0] r;
        for (int w = 0; w < 12; w++) r[w*32 +: 32] = (s * 32'h7F4A7C15) + (w * 32'h11111111) + 32'hC3;
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_slot(int i);
        case (i)
            0: return mod_m;
            1: return rnd_data_i;
            2: return urnd_data_i;
            3: return acc_m;
            4: return key0_valid_i ? key0_data_i[255:0] : '0;
            5: return key0_valid_i ? {128'b0, key0_data_i[383:256]} : '0;
            6: return key1_valid_i ? key1_data_i[255:0] : '0;
            default: return key1_valid_i ? {128'b0, key1_data_i[383:256]} : '0;
        endcase
    endfunction

    function automatic logic exp_has(int i);
        if (i < 4) return 1'b1;
        if (i < 6) return key0_valid_i;
        return key1_valid_i;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic look(string tag, int i);
        rd_idx_i = 3'(i);
        #1;
        chk(tag, rd_data_o, exp_slot(i));
    endtask

    // Full sweep of all eight indices: R1 R2 R3 R4 R12
    task automatic sweep(string tag);
        for (int i = 0; i < 8; i++) begin
            rd_idx_i = 3'(i);
            #1;
            chk({tag, " R1 data"}, rd_data_o, exp_slot(i));
            chk({tag, " R4 has"}, DW'(rd_has_value_o), DW'(exp_has(i)));
            chk({tag, " R12 word"}, DW'(rd_word_o), DW'(exp_slot(i) & 256'hFFFFFFFF));
            chk({tag, " R12 idx_ok"}, DW'(idx_ok_o), DW'(1));
        end
    endtask

    task automatic wr(int idx, logic [DW-1:0] d);
        wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic do_commit(); commit_i = 1'b1; step(); commit_i = 1'b0; endtask
    task automatic do_abort();  abort_i  = 1'b1; step(); abort_i  = 1'b0; endtask
    task automatic do_wipe();   wipe_i   = 1'b1; step(); wipe_i   = 1'b0; endtask
    task automatic do_start();  start_i  = 1'b1; step(); start_i  = 1'b0; endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_ni = 1'b1;
        step();

        // R13 reset state, keys invalid read zero
        sweep("R13 reset");

        // R2 R3 valid keys
        key0_data_i = pat384(1); key1_data_i = pat384(2);
        key0_valid_i = 1'b1; key1_valid_i = 1'b1;
        rnd_data_i = pat256(3); urnd_data_i = pat256(4);
        sweep("R2 R3 keys");

        // R6 staged write invisible until commit
        wr(0, pat256(10));
        look("R6 before commit", 0);
        do_commit(); mod_m = pat256(10);
        look("R6 after commit", 0);
        wr(3, pat256(11)); do_commit(); acc_m = pat256(11);
        look("R6 acc commit", 3);

        // R7 abort discards
        wr(3, pat256(12)); do_abort(); do_commit();
        look("R7 abort", 3);

        // R5 writes to read-only slots
        for (int i = 1; i < 8; i++) if (i != 3) wr(i, pat256(20 + i));
        do_commit();
        sweep("R5 ignored");

        // R9 key change without clock, and abort/commit do not undo it
        key0_valid_i = 1'b0; #1;
        look("R9 key0 drop lo", 4);
        look("R9 key0 drop hi", 5);
        key0_data_i = pat384(5); key0_valid_i = 1'b1;
        do_abort(); do_commit();
        sweep("R9 after abort");

        // R10 wipe
        do_wipe(); do_commit();
        look("R10 wipe commit mod", 0); look("R10 wipe commit acc", 3);
        do_wipe(); wr(0, pat256(30)); do_commit(); mod_m = pat256(30);
        look("R10 write after wipe", 0);
        wr(3, pat256(31)); do_wipe(); do_commit();
        look("R10 wipe after write", 3);

        // R11 precedence
        wr_en_i = 1'b1; wr_idx_i = 3'd0; wr_data_i = pat256(40); commit_i = 1'b1;
        step(); wr_en_i = 1'b0; commit_i = 1'b0;
        do_commit();
        look("R11 write with commit dropped", 0);
        wr(0, pat256(41));
        commit_i = 1'b1; abort_i = 1'b1; step(); commit_i = 1'b0; abort_i = 1'b0;
        do_commit();
        look("R11 abort beats commit", 0);
        wr_en_i = 1'b1; wr_idx_i = 3'd3; wr_data_i = pat256(42); wipe_i = 1'b1;
        step(); wr_en_i = 1'b0; wipe_i = 1'b0;
        do_commit();
        look("R11 wipe beats write", 3);

        // R8 start clears and drops pending
        wr(3, pat256(50));
        do_start(); mod_m = '0; acc_m = '0;
        look("R8 start mod", 0); look("R8 start acc", 3);
        do_commit();
        sweep("R8 pending dropped");

        // Sweep many value sets
        for (int n = 0; n < 24; n++) begin
            wr(0, pat256(100 + n)); wr(3, pat256(200 + n));
            if (n % 3 == 0) begin
                do_abort();
            end else begin
                do_commit(); mod_m = pat256(100 + n); acc_m = pat256(200 + n);
            end
            rnd_data_i = pat256(300 + n); urnd_data_i = pat256(400 + n);
            key0_data_i = pat384(500 + n); key1_data_i = pat384(600 + n);
            key0_valid_i = n[0]; key1_valid_i = n[1];
            sweep("R6 R7 loop");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule